// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers level-sensitive interrupt requests from sixteen sources and decides which one, if any, is presented to the CPU. Each source has its own programmable 4-bit urgency level. Among the sources that are requesting, the one with the highest level is chosen. When several share that highest level, the source with the lowest index wins. The chosen level is compared against the CPU's current 4-bit mask level, and the request is presented only when it is strictly higher than the mask.

While a request is presented, the block holds a CPU request line high together with a stable vector number and level. The vector number is a base of 64 plus the source index. The CPU answers with a one-cycle acknowledge. At that acknowledge the block records the accepted vector and level, which the CPU copies into its mask.

An active-low interrupt pin is low while a request is presented. It returns high after acceptance, unless a request above the level just accepted is already waiting. In that case the pin stays low and the new request is presented at once.

Levels are programmed through a synchronous write port. Each 16-bit word carries four 4-bit level fields.

The control state machine has three states:
- ST_IDLE: nothing presented.
- ST_PRESENT: a request is held for the CPU.
- ST_SETTLE: a one-cycle gap after acceptance, during which the CPU updates its mask.

Its transitions are:
- IDLE→PRESENT: the winning level is above the mask.
- PRESENT→PRESENT: acknowledge arrives while a level above the accepted one is pending (a reload).
- PRESENT→SETTLE: acknowledge arrives with no such higher level pending.
- SETTLE→IDLE: always, after one cycle.

Top module: `prio_intc`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at word `wr_addr`. Bits [4j+3:4j] of word a become the level of source 4a+j. After reset every level is 0.
- R2: Among requesting sources, the presented request carries the highest programmed level, and `req_lvl` equals that level.
- R3: When several requesting sources share the highest level, the lowest-numbered source is presented.
- R4: A request is presented (`cpu_req` rises) only if its level is strictly greater than `cpu_mask`. A level equal to or below the mask, including level 0, never raises `cpu_req`.
- R5: While `cpu_req` is high and `cpu_ack` is low, `cpu_req`, `req_vec` and `req_lvl` hold their values, even if a higher request arrives. An acknowledge while `cpu_req` is low has no effect.
- R6: `req_vec` is 64 plus the source index. One cycle after an acknowledge of a presented request, `acc_vec` and `acc_lvl` hold the acknowledged `req_vec` and `req_lvl`.
- R7: `irq_n` is low exactly while `cpu_req` is high. After an acknowledge with no higher request pending, `irq_n` is high and `cpu_req` is low in the next cycle.
- R8: If, at the acknowledge, a requesting source has a level above the level being accepted, that source is presented in the next cycle and `irq_n` stays low.
- R9: After an acknowledge that leads to ST_SETTLE, `cpu_req` stays low for at least two cycles (the ST_SETTLE cycle and the following ST_IDLE cycle), even if a request above the mask is still asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 16 | Level-sensitive request per source |
| cpu_mask | input | 4 | CPU's current mask level |
| wr_en | input | 1 | Level register write strobe |
| wr_addr | input | 2 | Level register word select |
| wr_data | input | 16 | Four 4-bit level fields |
| cpu_ack | input | 1 | One-cycle acknowledge from the CPU |
| cpu_req | output | 1 | Request to the CPU |
| req_vec | output | 8 | Vector number of the presented request |
| req_lvl | output | 4 | Level of the presented request |
| acc_vec | output | 8 | Vector number latched at acknowledge |
| acc_lvl | output | 4 | Level latched at acknowledge |
| irq_n | output | 1 | Active-low interrupt output pin |

## Verification
The hardest situation to reach is the PRESENT→PRESENT reload. It needs a request to be held unacknowledged while a second source with a higher level starts requesting, and the acknowledge must fall exactly in that window. The bench gets there as follows:
- It presents a low-level source.
- It adds the high-level source while withholding the acknowledge, and checks that the presented request does not change.
- It then pulses the acknowledge and checks that the new vector appears in the next cycle with the pin still low.

The settle gap is reached by leaving a source asserted above an unchanged mask across an acknowledge.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LVL_W = 4;
    typedef logic [LVL_W-1:0] level_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRESENT = 2'd1,
        ST_SETTLE  = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/intc_level_regs.sv
module intc_level_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int DATA_W  = 16,
    localparam int FIELDS   = DATA_W / LVL_W,
    localparam int NUM_REGS = NUM_SRC / FIELDS,
    localparam int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [NUM_SRC*LVL_W-1:0]  levels_flat
);
    logic [DATA_W-1:0] words [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) words[r] <= '0;
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_flat
        assign levels_flat[r*DATA_W +: DATA_W] = words[r];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> levels_flat[$past(wr_addr)*DATA_W +: DATA_W] == $past(wr_data)) // R1
        else $error("level word write lost");
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic [NUM_SRC*LVL_W-1:0] levels_flat,
    output level_t                   win_lvl,
    output logic [IDX_W-1:0]         win_idx
);
    level_t eff [NUM_SRC];

    // A source that is not requesting competes with level 0, the same as a disabled one.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_eff
        assign eff[i] = src_req[i] ? levels_flat[i*LVL_W +: LVL_W] : '0;
    end

    // Strict comparison while scanning upward keeps the lower index on a tie.
    always_comb begin
        win_lvl = '0;
        win_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (eff[i] > win_lvl) begin
                win_lvl = eff[i];
                win_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                AST_WINNER_MAX: assert (eff[i] <= win_lvl) // R2
                    else $error("source %0d outranks the winner", i);
                AST_TIE_LOW_INDEX: assert (!(eff[i] != '0 && eff[i] == win_lvl) || IDX_W'(i) >= win_idx) // R3
                    else $error("tie not resolved to lowest index at %0d", i);
            end
        end
    end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
    import intc_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  level_t           win_lvl,
    input  logic [IDX_W-1:0] win_idx,
    input  level_t           cpu_mask,
    input  logic             cpu_ack,
    output logic             cpu_req,
    output logic [VEC_W-1:0] req_vec,
    output level_t           req_lvl,
    output logic [VEC_W-1:0] acc_vec,
    output level_t           acc_lvl,
    output logic             irq_n
);
    localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);

    ctrl_state_t state_q, state_d;
    logic        load_new;
    logic        take_ack;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        load_new = 1'b0;
        take_ack = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (win_lvl > cpu_mask) begin
                    state_d  = ST_PRESENT;
                    load_new = 1'b1;
                end
            end
            ST_PRESENT: begin
                if (cpu_ack) begin
                    take_ack = 1'b1;
                    if (win_lvl > req_lvl) begin
                        state_d  = ST_PRESENT;
                        load_new = 1'b1;
                    end else begin
                        state_d  = ST_SETTLE;
                    end
                end
            end
            ST_SETTLE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vec <= '0;
            req_lvl <= '0;
            acc_vec <= '0;
            acc_lvl <= '0;
        end else begin
            if (take_ack) begin
                acc_vec <= req_vec;
                acc_lvl <= req_lvl;
            end
            if (load_new) begin
                req_vec <= BASE_V + VEC_W'(win_idx);
                req_lvl <= win_lvl;
            end
        end
    end

    assign cpu_req = (state_q == ST_PRESENT);
    assign irq_n   = (state_q != ST_PRESENT);

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ack) |=> (cpu_req && $stable(req_vec) && $stable(req_lvl))) // R5
        else $error("presented request changed without acknowledge");
    AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_req) |-> (req_lvl > $past(cpu_mask))) // R4
        else $error("request presented at or below mask");
    AST_ACCEPT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack) |=> (acc_vec == $past(req_vec) && acc_lvl == $past(req_lvl))) // R6
        else $error("accepted vector or level not latched");
    AST_PIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_req) |-> (irq_n && $past(cpu_ack))) // R7
        else $error("request dropped without acknowledge or pin still low");
    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_req) |=> !cpu_req) // R9
        else $error("request re-presented without settle gap");
    AST_RELOAD_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack && win_lvl > req_lvl) |=> (cpu_req && !irq_n && req_lvl > $past(req_lvl))) // R8
        else $error("higher pending request not presented at acknowledge");
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int DATA_W   = 16,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    localparam int FIELDS   = DATA_W / LVL_W,
    localparam int NUM_REGS = NUM_SRC / FIELDS,
    localparam int ADDR_W   = $clog2(NUM_REGS),
    localparam int IDX_W    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [LVL_W-1:0]   cpu_mask,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               cpu_ack,
    output logic               cpu_req,
    output logic [VEC_W-1:0]   req_vec,
    output logic [LVL_W-1:0]   req_lvl,
    output logic [VEC_W-1:0]   acc_vec,
    output logic [LVL_W-1:0]   acc_lvl,
    output logic               irq_n
);
    logic [NUM_SRC*LVL_W-1:0] levels_flat;
    level_t                   win_lvl;
    logic [IDX_W-1:0]         win_idx;

    intc_level_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .levels_flat (levels_flat)
    );

    intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req     (src_req),
        .levels_flat (levels_flat),
        .win_lvl     (win_lvl),
        .win_idx     (win_idx)
    );

    intc_ctrl #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_lvl  (win_lvl),
        .win_idx  (win_idx),
        .cpu_mask (cpu_mask),
        .cpu_ack  (cpu_ack),
        .cpu_req  (cpu_req),
        .req_vec  (req_vec),
        .req_lvl  (req_lvl),
        .acc_vec  (acc_vec),
        .acc_lvl  (acc_lvl),
        .irq_n    (irq_n)
    );
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_req = '0;
    logic [3:0]  cpu_mask = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cpu_ack = 1'b0;
    logic        cpu_req;
    logic [7:0]  req_vec;
    logic [3:0]  req_lvl;
    logic [7:0]  acc_vec;
    logic [3:0]  acc_lvl;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int lv [16];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    prio_intc i_prio_intc (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .cpu_mask(cpu_mask),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cpu_ack(cpu_ack),
        .cpu_req(cpu_req), .req_vec(req_vec), .req_lvl(req_lvl),
        .acc_vec(acc_vec), .acc_lvl(acc_lvl), .irq_n(irq_n)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic program_levels();
        for (int r = 0; r < 4; r++) begin
            wr_en   = 1'b1;
            wr_addr = 2'(r);
            wr_data = {4'(lv[4*r+3]), 4'(lv[4*r+2]), 4'(lv[4*r+1]), 4'(lv[4*r])};
            step();
        end
        wr_en = 1'b0;
    endtask

    // One trial: present, hold, acknowledge, settle.
    task automatic run_trial(input logic [15:0] r, input logic [3:0] m, input string vtag);
        int best = 0;
        int idx  = 0;
        bit exp_req;
        for (int i = 0; i < 16; i++)
            if (r[i] && lv[i] > best) begin best = lv[i]; idx = i; end
        exp_req = (best > int'(m));
        src_req  = r;
        cpu_mask = m;
        step();
        check("R4", "cpu_req", int'(cpu_req), int'(exp_req));
        check("R7", "irq_n", int'(irq_n), int'(!exp_req));
        if (exp_req) begin
            check(vtag, "req_vec", int'(req_vec), 64 + idx);
            check("R2", "req_lvl", int'(req_lvl), best);
            step();
            check("R5", "held vec", int'(cpu_req ? req_vec : 8'd0), 64 + idx);
            cpu_ack = 1'b1;
            src_req = '0;
            step();
            cpu_ack = 1'b0;
            check("R6", "acc_vec", int'(acc_vec), 64 + idx);
            check("R6", "acc_lvl", int'(acc_lvl), best);
            check("R7", "irq_n after ack", int'(irq_n), 1);
            step();
        end else begin
            src_req = '0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // Reset state
        check("R7", "reset cpu_req", int'(cpu_req), 0);
        check("R7", "reset irq_n", int'(irq_n), 1);
        check("R6", "reset acc_vec", int'(acc_vec), 0);
        src_req = 16'hFFFF; cpu_mask = '0;
        step(); step();
        check("R1", "levels zero after reset", int'(cpu_req), 0);
        src_req = '0;
        step();

        // Level set A: distinct-ish levels, sweep masks
        for (int i = 0; i < 16; i++) lv[i] = (i * 5 + 3) % 16;
        program_levels();
        for (int t = 0; t < 80; t++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_trial(lfsr, 4'(t % 16), "R2");
        end
        // Level set B: four ties per word (R3)
        for (int i = 0; i < 16; i++) lv[i] = (i / 4) * 3 + 2;
        program_levels();
        for (int t = 0; t < 60; t++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_trial(lfsr & 16'h0F0F, 4'(t % 12), "R3");
        end
        // Level set C: all tied, single-bit and paired requests (R3)
        for (int i = 0; i < 16; i++) lv[i] = 7;
        program_levels();
        for (int a = 0; a < 16; a++) begin
            run_trial(16'(1) << a | 16'(1) << ((a * 7 + 3) % 16), 4'd6, "R3");
            run_trial(16'(1) << a, 4'd7, "R4");
        end
        // Single field write: R1 field placement
        for (int i = 0; i < 16; i++) lv[i] = 0;
        program_levels();
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0900; step(); wr_en = 1'b0;
        lv[10] = 9;
        run_trial(16'hFFFF, 4'd8, "R1");

        // R8: higher request arrives while presented, acknowledge reloads
        for (int i = 0; i < 16; i++) lv[i] = 0;
        lv[5] = 3; lv[9] = 12;
        program_levels();
        cpu_mask = 4'd0;
        src_req = 16'h0020;
        step();
        check("R5", "low source presented", int'(req_vec), 69);
        src_req = 16'h0220;
        step();
        check("R5", "vec held despite higher", int'(req_vec), 69);
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        check("R8", "reload cpu_req", int'(cpu_req), 1);
        check("R8", "reload vec", int'(req_vec), 73);
        check("R8", "reload lvl", int'(req_lvl), 12);
        check("R8", "irq_n stays low", int'(irq_n), 0);
        check("R6", "acc_vec of first", int'(acc_vec), 69);
        src_req = '0;
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        check("R6", "acc_lvl second", int'(acc_lvl), 12);
        step();

        // R9: source kept asserted above an unchanged mask
        src_req = 16'h0020;
        step();
        check("R4", "presented for gap test", int'(cpu_req), 1);
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        check("R9", "settle cycle", int'(cpu_req), 0);
        step();
        check("R9", "idle cycle", int'(cpu_req), 0);
        step();
        check("R9", "re-presented after gap", int'(cpu_req), 1);
        src_req = '0;
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        step(); step();

        // R5: acknowledge while idle is ignored
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        step();
        check("R5", "idle ack cpu_req", int'(cpu_req), 0);
        check("R5", "idle ack acc_vec", int'(acc_vec), 69);
        check("R5", "idle ack irq_n", int'(irq_n), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule